// File: doc/BRIEF.md
# Interval Timer Bus Front End

This block is the byte-wide register front end of a three-channel interval timer. It decodes four addresses: the three channel data ports at addresses 0, 1 and 2, and the control port at address 3. Control bytes set a channel's access mode, counting mode and BCD flag. They also carry the count-snapshot command and the multi-channel read-back command. The block keeps the byte-order state of each channel for reads and for writes. It holds count and status snapshots until they are read. It assembles 16-bit initial counts and issues them to the counter channels as one-cycle load pulses.

The counters themselves are outside this block. They supply their live 16-bit counts and their output levels, and they take the load pulses and the configured modes. The bus is a single-cycle strobe interface. A read strobe yields its byte on `rdata` from the next cycle on. `rdata` holds that byte until the next read. Reads and writes share one address, and both strobes may be active in the same cycle.

Top module: `timer_bus_frontend`

## Requirements
- R1: After reset `rdata` is 0, `load_valid` is 0, every channel reports mode 0 and BCD 0, its access mode is word (low byte then high byte), and its null-count flag is set.
- R2: A write to address 3 with bits 7:6 = channel (0..2) and bits 5:4 nonzero sets that channel's access mode to bits 5:4 (1 = low byte only, 2 = high byte only, 3 = word). It sets the counting mode to bits 3:1, with 6 stored as 2 and 7 stored as 3, and the BCD flag to bit 0. These show on `chan_mode[3c+2:3c]` and `chan_bcd[c]` in the next cycle. The same write returns both byte toggles of the channel to the low byte, drops any pending snapshot and sets the null-count flag.
- R3: In low-byte access a data write loads {8'h00, byte}. In high-byte access it loads {byte, 8'h00}. The load appears as a one-cycle pulse on `load_valid[c]` with `load_value[16c+15:16c]` in the cycle after the write.
- R4: In word access the first data write is held without a load. The second write loads {second, first} and returns the write toggle to the low byte.
- R5: A read of a channel with no snapshot returns the live count byte: the low byte in low-byte access, the high byte in high-byte access, and alternately low then high (starting low) in word access. `rdata` changes only on a read.
- R6: A control byte with bits 5:4 = 0 snapshots the selected channel's live count. Later reads return the snapshot whatever the live count does. In low-byte or high-byte access one read releases it. In word access it is read low byte then high byte and released after the high byte. Reading the snapshot does not move the live-read toggle.
- R7: A snapshot command for a channel whose count snapshot (or status snapshot, for a status request) is still unread at the start of that cycle is ignored, and the older snapshot is kept.
- R8: A control byte with bits 7:6 = 3 is a read-back command. It applies to channel c when bit (1 + c) is set. It snapshots the count when bit 5 is 0 and the status when bit 4 is 0. The status byte is {output level, null count, access[1:0], mode[2:0], BCD}, MSB first. The null-count flag stays set from a control write until the channel's count has been fully loaded.
- R9: A read returns a pending status snapshot first and clears it, then a pending count snapshot, then the live count.
- R10: A read of address 3 returns 0 and changes no channel state.
- R11: A read and a write of the same data address in the same cycle both take effect. The read returns the byte selected by the state before that cycle. The read and write byte toggles advance independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address (0..2 channel data, 3 control) |
| wdata | input | 8 | Write byte |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| rdata | output | 8 | Read byte, valid from the cycle after `rd_en` |
| live_count | input | 48 | Live counts of the channels, channel c at bits 16c+15:16c |
| live_out | input | 3 | Output levels of the channels |
| load_valid | output | 3 | One-cycle load pulse per channel |
| load_value | output | 48 | Initial count per channel, channel c at bits 16c+15:16c |
| chan_mode | output | 9 | Counting mode per channel, 3 bits each |
| chan_bcd | output | 3 | BCD flag per channel |

## Verification
Because reads and writes share the address, a data read and a data write can hit the same channel in the same cycle. The bench drives both strobes together on a channel in word access that also holds a count snapshot. It expects the read to return the snapshot bytes, low then high. It expects the write to hold the first byte and to load the combined word on the second, with no load after the first. A second case pairs a snapshot command with a pending snapshot and live-count changes, and expects the older snapshot to be kept.

// File: rtl/timer_bus_pkg.sv
package timer_bus_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 16;
    localparam int NUM_CH = 3;
    localparam int MODE_W = 3;
    localparam int ACC_W  = 2;
    localparam int ADDR_W = 2;

    typedef enum logic [ACC_W-1:0] {
        ACC_SNAP = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_WORD = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
        logic              rd_hi;
        logic              wr_hi;
        logic [BYTE_W-1:0] wr_lo;
        logic              cnt_lat;
        logic              cnt_hi;
        logic [CNT_W-1:0]  cnt_snap;
        logic              sts_lat;
        logic [BYTE_W-1:0] sts_snap;
        logic              null_cnt;
        logic              load;
        logic [CNT_W-1:0]  load_val;
    } chan_st_t;
endpackage

// File: rtl/timer_chan_port.sv
module timer_chan_port
    import timer_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [5:0]        ctl_bits,
    input  logic              snap_cnt,
    input  logic              snap_sts,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic              live_lvl,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              bcd_o
);
    localparam int HB = CNT_W - BYTE_W;

    chan_st_t s_d, s_q;
    logic [MODE_W-1:0] new_mode;

    always_comb begin
        s_d      = s_q;
        s_d.load = 1'b0;
        new_mode = ctl_bits[3:1];
        if (new_mode > 3'd5) new_mode = new_mode - 3'd4;

        if (s_q.sts_lat)      rd_byte = s_q.sts_snap;
        else if (s_q.cnt_lat) rd_byte = s_q.cnt_hi ? s_q.cnt_snap[CNT_W-1:HB] : s_q.cnt_snap[BYTE_W-1:0];
        else begin
            case (s_q.acc)
                ACC_HI:   rd_byte = live_cnt[CNT_W-1:HB];
                ACC_WORD: rd_byte = s_q.rd_hi ? live_cnt[CNT_W-1:HB] : live_cnt[BYTE_W-1:0];
                default:  rd_byte = live_cnt[BYTE_W-1:0];
            endcase
        end

        if (data_rd) begin
            if (s_q.sts_lat) s_d.sts_lat = 1'b0;
            else if (s_q.cnt_lat) begin
                if (s_q.acc == ACC_WORD && !s_q.cnt_hi) s_d.cnt_hi  = 1'b1;
                else                                    s_d.cnt_lat = 1'b0;
            end else if (s_q.acc == ACC_WORD) s_d.rd_hi = !s_q.rd_hi;
        end

        if (data_wr) begin
            case (s_q.acc)
                ACC_LO: begin
                    s_d.load = 1'b1; s_d.load_val = {{HB{1'b0}}, wbyte}; s_d.null_cnt = 1'b0;
                end
                ACC_HI: begin
                    s_d.load = 1'b1; s_d.load_val = {wbyte, {BYTE_W{1'b0}}}; s_d.null_cnt = 1'b0;
                end
                ACC_WORD: begin
                    if (!s_q.wr_hi) begin
                        s_d.wr_lo = wbyte; s_d.wr_hi = 1'b1;
                    end else begin
                        s_d.load = 1'b1; s_d.load_val = {wbyte, s_q.wr_lo};
                        s_d.wr_hi = 1'b0; s_d.null_cnt = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        if (ctl_wr) begin
            s_d.acc      = acc_e'(ctl_bits[5:4]);
            s_d.mode     = new_mode;
            s_d.bcd      = ctl_bits[0];
            s_d.rd_hi    = 1'b0;
            s_d.wr_hi    = 1'b0;
            s_d.cnt_lat  = 1'b0;
            s_d.sts_lat  = 1'b0;
            s_d.null_cnt = 1'b1;
        end

        if (snap_cnt && !s_q.cnt_lat) begin
            s_d.cnt_lat  = 1'b1;
            s_d.cnt_snap = live_cnt;
            s_d.cnt_hi   = (s_q.acc == ACC_HI);
        end
        if (snap_sts && !s_q.sts_lat) begin
            s_d.sts_lat  = 1'b1;
            s_d.sts_snap = {live_lvl, s_q.null_cnt, s_q.acc, s_q.mode, s_q.bcd};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.acc      <= ACC_WORD;
            s_q.null_cnt <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign load_o     = s_q.load;
    assign load_val_o = s_q.load_val;
    assign mode_o     = s_q.mode;
    assign bcd_o      = s_q.bcd;

    // R9: a read consumes a pending status snapshot
    p_sts_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sts_lat && data_rd |=> !s_q.sts_lat);
    // R7: a pending count snapshot survives a further snapshot command
    p_snap_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt_lat && snap_cnt && !data_rd && !ctl_wr |=> $stable(s_q.cnt_snap));
    // R4: the first byte of a word write produces no load
    p_word_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && s_q.acc == ACC_WORD && !s_q.wr_hi |=> !load_o);
    // R3: high-byte access loads a zero low half
    p_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_o && s_q.acc == ACC_HI |-> load_val_o[BYTE_W-1:0] == '0);
endmodule

// File: rtl/timer_bus_frontend.sv
module timer_bus_frontend
    import timer_bus_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [BYTE_W-1:0]        wdata,
    input  logic                     wr_en,
    input  logic                     rd_en,
    output logic [BYTE_W-1:0]        rdata,
    input  logic [NUM_CH*CNT_W-1:0]  live_count,
    input  logic [NUM_CH-1:0]        live_out,
    output logic [NUM_CH-1:0]        load_valid,
    output logic [NUM_CH*CNT_W-1:0]  load_value,
    output logic [NUM_CH*MODE_W-1:0] chan_mode,
    output logic [NUM_CH-1:0]        chan_bcd
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH);

    logic              ctl_hit;
    logic              is_rb;
    logic [BYTE_W-1:0] ch_byte [NUM_CH];
    logic [BYTE_W-1:0] rdata_d, rdata_q;

    assign ctl_hit = wr_en && (addr == CTL_ADDR);
    assign is_rb   = (wdata[7:6] == 2'd3);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel, ctl_w, snap_c, snap_s;
        assign sel    = ctl_hit && (wdata[7:6] == 2'(c));
        assign ctl_w  = sel && (wdata[5:4] != 2'd0);
        assign snap_c = (sel && (wdata[5:4] == 2'd0)) ||
                        (ctl_hit && is_rb && wdata[c+1] && !wdata[5]);
        assign snap_s = ctl_hit && is_rb && wdata[c+1] && !wdata[4];

        timer_chan_port u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctl_wr     (ctl_w),
            .ctl_bits   (wdata[5:0]),
            .snap_cnt   (snap_c),
            .snap_sts   (snap_s),
            .data_wr    (wr_en && (addr == ADDR_W'(c))),
            .data_rd    (rd_en && (addr == ADDR_W'(c))),
            .wbyte      (wdata),
            .live_cnt   (live_count[c*CNT_W +: CNT_W]),
            .live_lvl   (live_out[c]),
            .rd_byte    (ch_byte[c]),
            .load_o     (load_valid[c]),
            .load_val_o (load_value[c*CNT_W +: CNT_W]),
            .mode_o     (chan_mode[c*MODE_W +: MODE_W]),
            .bcd_o      (chan_bcd[c])
        );
    end

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) begin
            if (addr == CTL_ADDR) rdata_d = '0;
            else                  rdata_d = ch_byte[addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    // R10: the control address reads as zero
    p_ctl_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == CTL_ADDR |=> rdata == '0);
    // R5: read data is held between reads
    p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/timer_bus_frontend_bench.sv
module timer_bus_frontend_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  addr = 0;
    logic [7:0]  wdata = 0;
    logic        wr_en = 0, rd_en = 0;
    logic [7:0]  rdata;
    logic [47:0] live_count = 0;
    logic [2:0]  live_out = 0;
    logic [2:0]  load_valid;
    logic [47:0] load_value;
    logic [8:0]  chan_mode;
    logic [2:0]  chan_bcd;

    int checks = 0, errors = 0;
    logic [7:0]  rq_exp[$];
    string       rq_tag[$];
    int          lq_ch[$];
    logic [15:0] lq_val[$];
    string       lq_tag[$];
    logic        rd_pend = 0;

    always #2.5 clk = ~clk;

    timer_bus_frontend u_timer_bus_frontend (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .live_count(live_count), .live_out(live_out),
        .load_valid(load_valid), .load_value(load_value), .chan_mode(chan_mode),
        .chan_bcd(chan_bcd)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: compares results against the scoreboard queues
    always @(posedge clk) rd_pend <= rd_en;
    always @(negedge clk) begin
        if (rst_n && rd_pend) begin
            if (rq_exp.size() == 0) chk(0, "unexpected read", rdata, 0);
            else begin
                logic [7:0] e; string t;
                e = rq_exp.pop_front(); t = rq_tag.pop_front();
                chk(rdata == e, t, rdata, e);
            end
        end
        for (int c = 0; c < 3; c++) begin
            if (rst_n && load_valid[c]) begin
                if (lq_ch.size() == 0) chk(0, "unexpected load", c, 0);
                else begin
                    int ec; logic [15:0] ev; string t;
                    ec = lq_ch.pop_front(); ev = lq_val.pop_front(); t = lq_tag.pop_front();
                    chk(ec == c, {t, " channel"}, c, ec);
                    chk(load_value[c*16 +: 16] == ev, t, load_value[c*16 +: 16], ev);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask
    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
        rq_exp.push_back(e); rq_tag.push_back(t);
        @(negedge clk); addr = a; rd_en = 1;
        @(negedge clk); rd_en = 0;
    endtask
    task automatic wr_rd(input logic [1:0] a, input logic [7:0] d, input logic [7:0] e, input string t);
        rq_exp.push_back(e); rq_tag.push_back(t);
        @(negedge clk); addr = a; wdata = d; wr_en = 1; rd_en = 1;
        @(negedge clk); wr_en = 0; rd_en = 0;
    endtask
    task automatic exp_load(input int c, input logic [15:0] v, input string t);
        lq_ch.push_back(c); lq_val.push_back(v); lq_tag.push_back(t);
    endtask
    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        live_count = {16'h3C71, 16'h2A5C, 16'h1234};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rdata == 0, "R1 rdata after reset", rdata, 0);
        chk(load_valid == 0, "R1 load_valid after reset", load_valid, 0);
        chk(chan_mode == 0, "R1 modes after reset", chan_mode, 0);
        chk(chan_bcd == 0, "R1 bcd after reset", chan_bcd, 0);

        // R2/R4: channel 0 word access, mode 2
        wr(3, 8'h34);
        chk(chan_mode[2:0] == 3'd2, "R2 ch0 mode", chan_mode[2:0], 2);
        wr(0, 8'h78);
        exp_load(0, 16'h5678, "R4 word load");
        wr(0, 8'h56);
        // R5: live word reads low then high
        rd(0, 8'h34, "R5 word live low");
        rd(0, 8'h12, "R5 word live high");

        // R2/R3: channel 1 low-byte, mode 7 -> 3, BCD
        wr(3, 8'h5F);
        chk(chan_mode[5:3] == 3'd3, "R2 mode 7 folded to 3", chan_mode[5:3], 3);
        chk(chan_bcd[1] == 1'b1, "R2 ch1 bcd", chan_bcd[1], 1);
        exp_load(1, 16'h00AB, "R3 low-byte load");
        wr(1, 8'hAB);
        rd(1, 8'h5C, "R5 low-byte live read");

        // R3: channel 2 high-byte, mode 0
        wr(3, 8'hA0);
        exp_load(2, 16'h9C00, "R3 high-byte load");
        wr(2, 8'h9C);
        rd(2, 8'h3C, "R5 high-byte live read");

        // R6: count snapshot in word access
        wr(3, 8'h00);
        live_count[15:0] = 16'hBEEF;
        rd(0, 8'h34, "R6 snapshot low");
        rd(0, 8'h12, "R6 snapshot high");
        rd(0, 8'hEF, "R6 live after release");

        // R7: second snapshot command ignored
        wr(3, 8'h00);
        live_count[15:0] = 16'h1111;
        wr(3, 8'h00);
        live_count[15:0] = 16'h2222;
        rd(0, 8'hEF, "R7 older snapshot low");
        rd(0, 8'hBE, "R7 older snapshot high");
        rd(0, 8'h22, "R7 live after release");

        // R8/R9: read-back of channels 0 and 2, count and status
        live_out = 3'b101;
        live_count[15:0] = 16'h4D2C;
        wr(3, 8'hCA);
        live_count[15:0] = 16'h0000;
        live_count[47:32] = 16'h0000;
        rd(0, 8'hB4, "R9 status before count ch0");
        rd(0, 8'h2C, "R8 readback count low ch0");
        rd(0, 8'h4D, "R8 readback count high ch0");
        rd(0, 8'h00, "R9 live after snapshots ch0");
        rd(2, 8'hA0, "R8 status ch2");
        rd(2, 8'h3C, "R8 readback count ch2");
        rd(2, 8'h00, "R9 live ch2");
        rd(1, 8'h5C, "R8 unselected ch1 live");

        // R8: null-count flag
        wr(3, 8'h5F);
        wr(3, 8'hE4);
        rd(1, 8'h57, "R8 status null count set");
        rd(1, 8'h5C, "R8 status only, no count snapshot");
        exp_load(1, 16'h0005, "R3 reload ch1");
        wr(1, 8'h05);
        wr(3, 8'hE4);
        rd(1, 8'h17, "R8 null count cleared after load");

        // R10: control address reads zero, state kept
        live_count[15:0] = 16'h7E81;
        wr(3, 8'h00);
        live_count[15:0] = 16'h0000;
        rd(3, 8'h00, "R10 control read");
        rd(0, 8'h81, "R10 snapshot intact low");
        rd(0, 8'h7E, "R10 snapshot intact high");

        // R11: read and write of the same data address together
        live_count[15:0] = 16'h6A95;
        wr(3, 8'h00);
        live_count[15:0] = 16'h0000;
        wr_rd(0, 8'h11, 8'h95, "R11 read low with first write");
        exp_load(0, 16'h2211, "R11 load on second write");
        wr_rd(0, 8'h22, 8'h6A, "R11 read high with second write");

        // R2: control word resets toggles
        live_count[15:0] = 16'hC3D4;
        wr(3, 8'h34);
        rd(0, 8'hD4, "R2 toggle low after control");
        wr(0, 8'h99);
        wr(3, 8'h34);
        rd(0, 8'hD4, "R2 read toggle reset again");
        wr(0, 8'h01);
        exp_load(0, 16'h0201, "R2 write toggle reset");
        wr(0, 8'h02);

        repeat (4) @(negedge clk);
        chk(rq_exp.size() == 0, "pending reads", rq_exp.size(), 0);
        chk(lq_ch.size() == 0, "pending loads", lq_ch.size(), 0);
        summary();
        $finish;
    end
endmodule